// File: doc/BRIEF.md
# Masked GPIO Port with Level Alarms

This block is a bidirectional general-purpose I/O port. Each bit has a direction register, an output shadow register that drives the pad, and a high-level alarm arm and a low-level alarm arm. Each pad is modelled as a data-out and output-enable pair. The incoming pad levels pass through a synchroniser before the port reads them back or uses them for alarms.

Software works the port through a small command interface. A strobe carries a 4-bit command code and a bit mask. The masked commands set or clear output bits, turn bits into inputs or outputs, arm high or low alarms, or disarm them. Two read commands return either the synchronised pins or the output shadow on a registered read-data bus. A single level-sensitive alarm line tells a waiting reader that some armed bit sits at its armed level.

Top module: `gpio_alarm_port`

## Requirements
- R1: Code 1 (set outputs), when `cmd_valid` is high, makes every shadow bit marked 1 in `cmd_mask` equal to 1 after the clock edge and leaves the other bits unchanged; `pad_out` always shows the shadow.
- R2: Code 2 (clear outputs) makes every marked shadow bit 0 and leaves the other bits unchanged.
- R3: Code 3 (arm high) arms a high-level alarm on each marked bit and removes any low-level arm from that bit, so a bit never holds both arms.
- R4: Code 4 (arm low) arms a low-level alarm on each marked bit and removes any high-level arm from that bit.
- R5: Code 5 (disarm) removes both arms from each marked bit.
- R6: Direction is 1 for output and 0 for input, and `pad_oe` shows it. Code 6 makes marked bits inputs and code 7 makes marked bits outputs; unmarked bits keep their direction. In the cycle after the command, `rd_data` holds the mask of all inputs (code 6) or of all outputs (code 7) after the change.
- R7: Code 8 loads `rd_data` with the synchronised pin levels and code 9 loads it with the output shadow, both as they were at the command's edge. `rd_data` changes only on codes 6 to 9.
- R8: A pad level reaches the synchronised pins on the second rising edge after it is presented. A read issued on the first edge still returns the old level.
- R9: `alarm` is high exactly when some bit is high-armed with its synchronised pin at 1, or low-armed with its synchronised pin at 0. It falls as soon as the condition goes away or the arm is removed.
- R10: While `rst_n` is low, all bits are inputs, the shadow is zero, no alarm is armed and `rd_data` is zero.
- R11: Code 0, codes 10 to 15, and any cycle with `cmd_valid` low leave the shadow, the directions, the arms and `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_code | input | 4 | Command code |
| cmd_mask | input | WIDTH | Bit mask for the command |
| rd_data | output | WIDTH | Registered read-back value |
| pad_in | input | WIDTH | Raw pad levels |
| pad_out | output | WIDTH | Pad data out (output shadow) |
| pad_oe | output | WIDTH | Pad output enable (direction) |
| alarm | output | 1 | Level alarm, OR over all armed bits |

## Verification
The assertions assume `cmd_code` and `cmd_mask` are defined whenever `cmd_valid` is high. They also assume `pad_in` holds no X or Z values, because they compare synchronised pin values and alarm terms bit by bit. The bench drives every input at the falling clock edge with known values only, including pads that are inputs, and it keeps pads constant across each directed alarm scenario. That way the two-edge synchroniser delay can be predicted exactly. The random phase uses all sixteen codes, random masks and random pad values, so the assumptions still hold while undefined codes are sent.

// File: rtl/gpio_alarm_pkg.sv
package gpio_alarm_pkg;

   typedef enum logic [3:0] {
      CMD_NOP         = 4'd0,
      CMD_SET_OUT     = 4'd1,
      CMD_CLR_OUT     = 4'd2,
      CMD_ARM_HIGH    = 4'd3,
      CMD_ARM_LOW     = 4'd4,
      CMD_DISARM      = 4'd5,
      CMD_MAKE_IN     = 4'd6,
      CMD_MAKE_OUT    = 4'd7,
      CMD_READ_PINS   = 4'd8,
      CMD_READ_SHADOW = 4'd9
   } cmd_e;

   typedef struct packed {
      logic set_out;
      logic clr_out;
      logic arm_hi;
      logic arm_lo;
      logic disarm;
      logic make_in;
      logic make_out;
      logic rd_pins;
      logic rd_shadow;
   } strobe_t;

endpackage

// File: rtl/gpio_cmd_decode.sv
module gpio_cmd_decode
   import gpio_alarm_pkg::*;
(
   input  logic       cmd_valid,
   input  logic [3:0] cmd_code,
   output strobe_t    stb
);

   always_comb begin
      stb = '0;
      if (cmd_valid) begin
         case (cmd_code)
            CMD_SET_OUT:     stb.set_out   = 1'b1;
            CMD_CLR_OUT:     stb.clr_out   = 1'b1;
            CMD_ARM_HIGH:    stb.arm_hi    = 1'b1;
            CMD_ARM_LOW:     stb.arm_lo    = 1'b1;
            CMD_DISARM:      stb.disarm    = 1'b1;
            CMD_MAKE_IN:     stb.make_in   = 1'b1;
            CMD_MAKE_OUT:    stb.make_out  = 1'b1;
            CMD_READ_PINS:   stb.rd_pins   = 1'b1;
            CMD_READ_SHADOW: stb.rd_shadow = 1'b1;
            default:         stb = '0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_in,
   output logic [WIDTH-1:0] sync_out
);

   localparam int LAST = STAGES - 1;

   initial begin
      assert (STAGES >= 2 && STAGES <= 8)
         else $error("gpio_in_sync: STAGES must lie in 2..8");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= raw_in;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign sync_out = chain[LAST];

   // R8: the synchronised value is the raw value presented STAGES edges earlier.
   // Only the fixed two-stage case can be checked with a fixed $past depth.
   generate
      if (STAGES == 2) begin : g_chk2
         a_r8_two_edge_delay: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |=> sync_out == $past(raw_in, 2));
      end
   endgenerate

endmodule

// File: rtl/gpio_bit_regs.sv
module gpio_bit_regs #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_out,
   input  logic             clr_out,
   input  logic             make_in,
   input  logic             make_out,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] shadow,
   output logic [WIDTH-1:0] dir
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (set_out) begin
         shadow <= shadow | mask;
      end else if (clr_out) begin
         shadow <= shadow & ~mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir <= '0;
      end else if (make_in) begin
         dir <= dir & ~mask;
      end else if (make_out) begin
         dir <= dir | mask;
      end
   end

   a_r1_set_marked: assert property (@(posedge clk) disable iff (!rst_n)
      set_out |=> ((shadow & $past(mask)) == $past(mask)) &&
                  (((shadow ^ $past(shadow)) & ~$past(mask)) == '0));

   a_r2_clear_marked: assert property (@(posedge clk) disable iff (!rst_n)
      clr_out |=> ((shadow & $past(mask)) == '0) &&
                  (((shadow ^ $past(shadow)) & ~$past(mask)) == '0));

   a_r6_make_in_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
      make_in |=> ((dir & $past(mask)) == '0) &&
                  (((dir ^ $past(dir)) & ~$past(mask)) == '0));

   a_r6_make_out_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
      make_out |=> ((dir & $past(mask)) == $past(mask)) &&
                   (((dir ^ $past(dir)) & ~$past(mask)) == '0));

endmodule

// File: rtl/gpio_alarm_unit.sv
module gpio_alarm_unit #(
   parameter int WIDTH   = 32,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_hi,
   input  logic             arm_lo,
   input  logic             disarm,
   input  logic [WIDTH-1:0] mask,
   input  logic [WIDTH-1:0] pins,
   output logic             alarm
);

   logic [WIDTH-1:0] hi_armed;
   logic [WIDTH-1:0] lo_armed;
   logic [WIDTH-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_armed <= '0;
         lo_armed <= '0;
      end else if (arm_hi) begin
         hi_armed <= hi_armed | mask;
         lo_armed <= lo_armed & ~mask;
      end else if (arm_lo) begin
         lo_armed <= lo_armed | mask;
         hi_armed <= hi_armed & ~mask;
      end else if (disarm) begin
         hi_armed <= hi_armed & ~mask;
         lo_armed <= lo_armed & ~mask;
      end
   end

   assign hit = (hi_armed & pins) | (lo_armed & ~pins);

   generate
      if (REG_OUT) begin : g_reg
         logic alarm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) alarm_q <= 1'b0;
            else        alarm_q <= |hit;
         end
         assign alarm = alarm_q;
      end else begin : g_comb
         assign alarm = |hit;
         // R9: no alarm without an armed bit
         a_r9_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
            alarm |-> ((hi_armed | lo_armed) != '0));
      end
   endgenerate

   a_r3_arms_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_armed & lo_armed) == '0);

   a_r5_disarm_marked: assert property (@(posedge clk) disable iff (!rst_n)
      disarm |=> ((hi_armed | lo_armed) & $past(mask)) == '0);

   a_r4_arm_low_marked: assert property (@(posedge clk) disable iff (!rst_n)
      arm_lo |=> (lo_armed & $past(mask)) == $past(mask));

endmodule

// File: rtl/gpio_alarm_port.sv
module gpio_alarm_port
   import gpio_alarm_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit ALARM_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [3:0]       cmd_code,
   input  logic [WIDTH-1:0] cmd_mask,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic             alarm
);

   initial begin
      assert (WIDTH >= 1 && WIDTH <= 32)
         else $error("gpio_alarm_port: WIDTH must lie in 1..32");
   end

   strobe_t          stb;
   logic [WIDTH-1:0] pins_sync;
   logic [WIDTH-1:0] shadow;
   logic [WIDTH-1:0] dir;

   gpio_cmd_decode u_dec (
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .stb       (stb)
   );

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (pad_in),
      .sync_out (pins_sync)
   );

   gpio_bit_regs #(.WIDTH(WIDTH)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_out  (stb.set_out),
      .clr_out  (stb.clr_out),
      .make_in  (stb.make_in),
      .make_out (stb.make_out),
      .mask     (cmd_mask),
      .shadow   (shadow),
      .dir      (dir)
   );

   gpio_alarm_unit #(.WIDTH(WIDTH), .REG_OUT(ALARM_REG)) u_alarm (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_hi (stb.arm_hi),
      .arm_lo (stb.arm_lo),
      .disarm (stb.disarm),
      .mask   (cmd_mask),
      .pins   (pins_sync),
      .alarm  (alarm)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (stb.rd_pins) begin
         rd_data <= pins_sync;
      end else if (stb.rd_shadow) begin
         rd_data <= shadow;
      end else if (stb.make_in) begin
         rd_data <= ~dir | cmd_mask;
      end else if (stb.make_out) begin
         rd_data <= dir | cmd_mask;
      end
   end

   assign pad_out = shadow;
   assign pad_oe  = dir;

   a_r7_read_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      stb.rd_shadow |=> rd_data == $past(pad_out));

   a_r6_out_mask_matches_oe: assert property (@(posedge clk) disable iff (!rst_n)
      stb.make_out |=> rd_data == pad_oe);

   a_r6_in_mask_matches_oe: assert property (@(posedge clk) disable iff (!rst_n)
      stb.make_in |=> rd_data == ~pad_oe);

   a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(pad_out) && $stable(pad_oe) && $stable(rd_data));

endmodule

// File: tb/sim_gpio_alarm_port.sv
module sim_gpio_alarm_port;

   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic [3:0]   cmd_code = 4'd0;
   logic [W-1:0] cmd_mask = '0;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] rd_data, pad_out, pad_oe;
   logic         alarm;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_alarm_port u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_mask(cmd_mask), .rd_data(rd_data), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .alarm(alarm)
   );

   // behavioural reference
   logic [W-1:0] m_sh, m_dir, m_hi, m_lo, m_rd;
   logic [W-1:0] pin_hist [$];

   function automatic logic m_alarm();
      logic [W-1:0] p;
      p = pin_hist[0];
      return ((m_hi & p) | (m_lo & ~p)) != '0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sh = '0; m_dir = '0; m_hi = '0; m_lo = '0; m_rd = '0;
         pin_hist = {};
         pin_hist.push_back('0);
         pin_hist.push_back('0);
      end else begin
         if (cmd_valid) begin
            case (int'(cmd_code))
               1: m_sh = m_sh | cmd_mask;
               2: m_sh = m_sh & ~cmd_mask;
               3: begin m_hi = m_hi | cmd_mask; m_lo = m_lo & ~cmd_mask; end
               4: begin m_lo = m_lo | cmd_mask; m_hi = m_hi & ~cmd_mask; end
               5: begin m_hi = m_hi & ~cmd_mask; m_lo = m_lo & ~cmd_mask; end
               6: begin m_dir = m_dir & ~cmd_mask; m_rd = ~m_dir; end
               7: begin m_dir = m_dir | cmd_mask; m_rd = m_dir; end
               8: m_rd = pin_hist[0];
               9: m_rd = m_sh;
               default: ;
            endcase
         end
         void'(pin_hist.pop_front());
         pin_hist.push_back(pad_in);
      end
   end

   task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic compare_all();
      if (rst_n) begin
         check("R1/R2 pad_out vs model", pad_out, m_sh);
         check("R6 pad_oe vs model", pad_oe, m_dir);
         check("R7 rd_data vs model", rd_data, m_rd);
         check("R9 alarm vs model", {31'd0, alarm}, {31'd0, m_alarm()});
      end
   endtask

   task automatic cyc(input logic v, input logic [3:0] c, input logic [W-1:0] m, input logic [W-1:0] p);
      @(negedge clk);
      compare_all();
      cmd_valid = v; cmd_code = c; cmd_mask = m; pad_in = p;
   endtask

   task automatic cmd(input logic [3:0] c, input logic [W-1:0] m);
      cyc(1'b1, c, m, pad_in);
   endtask

   task automatic idle();
      cyc(1'b0, 4'd0, '0, pad_in);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 pad_out in reset", pad_out, '0);
      check("R10 pad_oe in reset", pad_oe, '0);
      check("R10 rd_data in reset", rd_data, '0);
      check("R10 alarm in reset", {31'd0, alarm}, '0);
      rst_n = 1'b1;
      idle();

      cmd(4'd1, 32'h0000_00F0); idle();
      check("R1 set low nibble", pad_out, 32'h0000_00F0);
      cmd(4'd1, 32'h8000_0001); idle();
      check("R1 set keeps others", pad_out, 32'h8000_00F1);
      cmd(4'd2, 32'h0000_0030); idle();
      check("R2 clear marked", pad_out, 32'h8000_00C1);

      cmd(4'd7, 32'h0000_FFFF); idle();
      check("R6 make output oe", pad_oe, 32'h0000_FFFF);
      check("R6 make output rd", rd_data, 32'h0000_FFFF);
      cmd(4'd6, 32'h0000_00FF); idle();
      check("R6 make input oe", pad_oe, 32'h0000_FF00);
      check("R6 make input rd", rd_data, 32'hFFFF_00FF);

      cmd(4'd9, '0); idle();
      check("R7 read shadow", rd_data, 32'h8000_00C1);

      cmd(4'd14, 32'hFFFF_FFFF); idle();
      check("R11 undefined code shadow", pad_out, 32'h8000_00C1);
      check("R11 undefined code oe", pad_oe, 32'h0000_FF00);
      check("R11 undefined code rd", rd_data, 32'h8000_00C1);
      cyc(1'b0, 4'd1, 32'hFFFF_FFFF, pad_in); idle();
      check("R11 valid low shadow", pad_out, 32'h8000_00C1);
      cyc(1'b0, 4'd7, 32'hFFFF_FFFF, pad_in); idle();
      check("R11 valid low oe", pad_oe, 32'h0000_FF00);

      cyc(1'b0, 4'd0, '0, 32'hA5A5_0000);
      cmd(4'd8, '0); idle();
      check("R8 read one edge after change", rd_data, 32'h0000_0000);
      cmd(4'd8, '0); idle();
      check("R7 R8 read pins after two edges", rd_data, 32'hA5A5_0000);

      cmd(4'd3, 32'h0001_0000); idle();
      check("R3 high alarm on high pin", {31'd0, alarm}, 32'd1);
      cmd(4'd5, 32'hFFFF_FFFF); idle();
      check("R5 disarm drops alarm", {31'd0, alarm}, 32'd0);
      cmd(4'd4, 32'h0002_0000); idle();
      check("R4 low alarm on low pin", {31'd0, alarm}, 32'd1);
      cyc(1'b0, 4'd0, '0, 32'hA5A7_0000); idle();
      check("R8 alarm still set one edge later", {31'd0, alarm}, 32'd1);
      idle();
      check("R9 alarm falls when level goes", {31'd0, alarm}, 32'd0);
      cmd(4'd3, 32'h0002_0000); idle();
      check("R3 rearm high on high pin", {31'd0, alarm}, 32'd1);
      cyc(1'b0, 4'd0, '0, 32'hA5A5_0000); idle(); idle();
      check("R3 arm high removed low arm", {31'd0, alarm}, 32'd0);
      cmd(4'd5, 32'hFFFF_FFFF); idle();

      for (int i = 0; i < 600; i++) begin
         logic [W-1:0] p;
         p = ($urandom_range(0, 3) == 0) ? W'($urandom) : pad_in;
         cyc(1'($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)), W'($urandom), p);
      end
      idle();

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 run did not finish got=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule